// File: doc/BRIEF.md
# I2C Serial Clock Rate Generator

This block derives the serial clock for an I2C master from a fast system clock. A two-bit predivider select picks a power-of-two predivision (4 to 32). An eight-bit divider and a one-bit input-filter setting then stretch each half of the clock. While the enable bit in the mode word is set, the block drives a free-running square wave on `scl_o`. It also gives a bit-level shifter two one-cycle strobes: one marks the first cycle of every low half, and the other marks the first cycle of every high half. The shifter may change SDA only during the low half.

Each half of the clock lasts `2^(5-psel) * (div + 3 + 2*filt)` system clocks, so the full period is twice that. The settings are sampled into a shadow register only when a period starts, which means a new setting never splits a period. Clearing the enable parks the output high. Setting the enable again starts a new period with its low half.

Top module: `scl_baud_gen`

## Requirements
- R1: While rst_ni is low, scl_o is 1 and low_tick_o and high_tick_o are 0.
- R2: Mode bits [2:1] select the predivider: 0 gives 32, 1 gives 16, 2 gives 8 and 3 gives 4 system clocks per step.
- R3: The low half and the high half of scl_o each last predivider * (div + 3 + 2*filt) cycles, where div is 0..255, so the period is twice that.
- R4: Mode bit [3] is the filter setting: when it is 1, each half grows by 2 * predivider cycles.
- R5: Only div_i[7:0] sets the rate. Bits above bit 7 have no effect on the phase lengths.
- R6: low_tick_o is high for exactly the first cycle of each low half, and high_tick_o is high for exactly the first cycle of each high half. The two are never high together.
- R7: Mode bit [0] is the enable. When the enable is 0, scl_o is 1 and both ticks are 0 from the next cycle on. When the enable rises, the next cycle starts a low half and pulses low_tick_o.
- R8: Changes to mode_i[3:1] or div_i while the generator runs take effect only at the start of the next period. The period in progress keeps its old lengths.
- R9: scl_o falls only in a cycle where low_tick_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Bit 0 is the enable, bits 2:1 the predivider select, bit 3 the filter setting |
| div_i | input | DIV_IN_W | Divider value; only the low DIV_W bits are used |
| scl_o | output | 1 | Serial clock waveform |
| low_tick_o | output | 1 | Strobe in the first cycle of each low half |
| high_tick_o | output | 1 | Strobe in the first cycle of each high half |

## Verification
The bench sweeps every predivider select with both filter settings, and it sweeps the divider across a low range and at its maximum of 255. For each setting it measures the low and high halves in cycles. An off-by-one in the step counter or the phase counter would make every half one step too long or too short, and a swapped select decode would scale the halves by the wrong power of two. A value with upper divider bits set checks that a design reading those bits runs at a different rate. Two further cases target the shadow register and the enable: a setting changed right after a low tick must leave the current period unchanged, and a mid-phase disable must park the clock high and restart cleanly. A design that loads settings on every cycle would give a period of mixed length in the first case. A design that resumes its old counts after a disable would give a short first half in the second.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  localparam int SBG_SEL_N  = 4;
  localparam int MODE_EN    = 0;
  localparam int MODE_PSEL  = 1;
  localparam int MODE_FILT  = 3;
  localparam int MODE_W     = 4;
  typedef logic [1:0] psel_t;
endpackage

// File: rtl/sbg_cfg_reg.sv
module sbg_cfg_reg
  import sbg_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int DIV_IN_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  psel_t               psel_i,
  input  logic                filt_i,
  input  logic [DIV_IN_W-1:0] div_i,
  output psel_t               psel_o,
  output logic                filt_o,
  output logic [DIV_W-1:0]    div_o
);
  logic unused_div_hi;
  assign unused_div_hi = ^div_i[DIV_IN_W-1:DIV_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psel_o <= '0;
      filt_o <= 1'b0;
      div_o  <= '0;
    end else if (load_i) begin
      psel_o <= psel_i;
      filt_o <= filt_i;
      div_o  <= div_i[DIV_W-1:0];
    end
  end
endmodule

// File: rtl/sbg_prescale.sv
module sbg_prescale
  import sbg_pkg::*;
#(
  parameter int PRE_LOG = 5
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  psel_t psel_i,
  output logic  step_o
);
  logic [PRE_LOG-1:0] cnt_q;
  logic [PRE_LOG-1:0] term [SBG_SEL_N];

  // select g divides by 2^(PRE_LOG-g)
  for (genvar g = 0; g < SBG_SEL_N; g++) begin : g_term
    assign term[g] = PRE_LOG'((1 << (PRE_LOG - g)) - 1);
  end

  logic at_term;
  assign at_term = (cnt_q == term[psel_i]);
  assign step_o  = run_i && at_term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (at_term) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assert_pre_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= term[psel_i]));
endmodule

// File: rtl/sbg_phase.sv
module sbg_phase #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             filt_i,
  output logic             end_o
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q, lim, last;
  assign lim  = CNT_W'(div_i) + CNT_W'(3) + CNT_W'({filt_i, 1'b0});
  assign last = lim - 1'b1;
  assign end_o = step_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (end_o)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  assert_half_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < lim));
endmodule

// File: rtl/scl_baud_gen.sv
module scl_baud_gen
  import sbg_pkg::*;
#(
  parameter int PRE_LOG  = 5,
  parameter int DIV_W    = 8,
  parameter int DIV_IN_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [DIV_IN_W-1:0] div_i,
  output logic                scl_o,
  output logic                low_tick_o,
  output logic                high_tick_o
);
  logic en, run_q, start, run, step, ph_end, load;
  psel_t psel_q;
  logic filt_q;
  logic [DIV_W-1:0] div_q;
  logic scl_q, lt_q, ht_q;

  assign en    = mode_i[MODE_EN];
  assign start = en && !run_q;
  assign run   = en && run_q;
  // shadow load at period start: enable edge or end of high half
  assign load  = start || (run && ph_end && scl_q);

  sbg_cfg_reg #(.DIV_W(DIV_W), .DIV_IN_W(DIV_IN_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .psel_i (mode_i[MODE_PSEL+1:MODE_PSEL]),
    .filt_i (mode_i[MODE_FILT]),
    .div_i  (div_i),
    .psel_o (psel_q),
    .filt_o (filt_q),
    .div_o  (div_q)
  );

  sbg_prescale #(.PRE_LOG(PRE_LOG)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .psel_i (psel_q),
    .step_o (step)
  );

  sbg_phase #(.DIV_W(DIV_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .step_i (step),
    .div_i  (div_q),
    .filt_i (filt_q),
    .end_o  (ph_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      scl_q <= 1'b1;
      lt_q  <= 1'b0;
      ht_q  <= 1'b0;
    end else if (!en) begin
      run_q <= 1'b0;
      scl_q <= 1'b1;
      lt_q  <= 1'b0;
      ht_q  <= 1'b0;
    end else if (start) begin
      run_q <= 1'b1;
      scl_q <= 1'b0;
      lt_q  <= 1'b1;
      ht_q  <= 1'b0;
    end else if (ph_end) begin
      scl_q <= !scl_q;
      lt_q  <= scl_q;
      ht_q  <= !scl_q;
    end else begin
      lt_q  <= 1'b0;
      ht_q  <= 1'b0;
    end
  end

  assign scl_o       = scl_q;
  assign low_tick_o  = lt_q;
  assign high_tick_o = ht_q;

  assert_tick_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(low_tick_o && high_tick_o));

  assert_fall_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_o) |-> low_tick_o);

  assert_idle_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[MODE_EN] |=> (scl_o && !low_tick_o && !high_tick_o));

  assert_cfg_at_period_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({psel_q, filt_q, div_q}) |-> low_tick_o);
endmodule

// File: tb/sim_scl_baud_gen.sv
module sim_scl_baud_gen;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] mode_i = '0;
  logic [15:0] div_i = '0;
  logic scl_o, low_tick_o, high_tick_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = !clk;

  scl_baud_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .div_i(div_i),
    .scl_o(scl_o), .low_tick_o(low_tick_o), .high_tick_o(high_tick_o)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int half(int sel, int f, int d);
    return (32 >> sel) * (d + 3 + 2 * f);
  endfunction

  task automatic start(int sel, int f, logic [15:0] d);
    @(negedge clk);
    mode_i = '0;
    @(negedge clk);
    mode_i = {f[0], sel[1:0], 1'b1};
    div_i  = d;
    @(negedge clk);
    chk(low_tick_o == 1'b1 && scl_o == 1'b0, "R7 restart tick", int'(low_tick_o), 1);
  endtask

  // entry: at negedge of first low cycle; exit: at negedge of next low_tick
  task automatic measure(int exp_h, string req);
    int lo = 0, hi = 0, lt = 0, ht = 0;
    while (scl_o == 1'b0 && lo < 20000) begin
      lo++; lt += int'(low_tick_o); ht += int'(high_tick_o);
      @(negedge clk);
    end
    chk(high_tick_o == 1'b1, "R6 high tick at rise", int'(high_tick_o), 1);
    while (scl_o == 1'b1 && hi < 20000) begin
      hi++; ht += int'(high_tick_o); lt += int'(low_tick_o);
      @(negedge clk);
    end
    chk(low_tick_o == 1'b1, "R9 low tick at fall", int'(low_tick_o), 1);
    chk(lo == exp_h, {req, " low half"}, lo, exp_h);
    chk(hi == exp_h, {req, " high half"}, hi, exp_h);
    chk(lt == 1 && ht == 1, "R6 one tick per half", lt * 10 + ht, 11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(scl_o == 1'b1 && !low_tick_o && !high_tick_o, "R1 reset state",
        int'({scl_o, low_tick_o, high_tick_o}), 4);
    rst_ni = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(scl_o && !low_tick_o && !high_tick_o, "R7 idle when disabled",
          int'({scl_o, low_tick_o, high_tick_o}), 4);
    end
    // R2, R4: all selects, both filter settings
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 2; f++) begin
        start(s, f, 16'd5);
        measure(half(s, f, 5), f ? "R4 filter" : "R2 predivider");
      end
    // R3: divider sweep
    for (int d = 0; d <= 40; d++) begin
      start(3, 0, 16'(d));
      measure(half(3, 0, d), "R3 divider");
    end
    start(3, 1, 16'd255);
    measure(half(3, 1, 255), "R3 max divider");
    start(0, 1, 16'd255);
    measure(half(0, 1, 255), "R3 max total");
    // R5: upper divider bits ignored
    start(3, 0, 16'hA503);
    measure(half(3, 0, 3), "R5 upper bits");
    start(1, 1, 16'hFF00);
    measure(half(1, 1, 0), "R5 upper bits zero div");
    // R8: change mid-period
    start(2, 0, 16'd4);
    mode_i = 4'b0111;
    div_i  = 16'd9;
    measure(half(2, 0, 4), "R8 old period kept");
    measure(half(3, 0, 9), "R8 new period applied");
    // R7: disable mid phase, then restart
    start(3, 0, 16'd10);
    repeat (7) @(negedge clk);
    mode_i[0] = 1'b0;
    @(negedge clk);
    chk(scl_o && !low_tick_o && !high_tick_o, "R7 disable parks high",
        int'({scl_o, low_tick_o, high_tick_o}), 4);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(scl_o && !low_tick_o && !high_tick_o, "R7 stays idle",
          int'({scl_o, low_tick_o, high_tick_o}), 4);
    end
    start(3, 0, 16'd10);
    measure(half(3, 0, 10), "R7 full period after restart");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule